// File: doc/BRIEF.md
# Byte/Word Integer Add-Subtract Unit with Status Flags

This block is the add/subtract part of an integer execution stage. Each cycle in which `op_valid` is high, it takes an operation code, a width select, a destination operand, a source operand and an external carry. It computes a sum or a difference at either byte or word width. On the next clock edge it registers the result, a write enable and six status flags: carry, auxiliary carry, overflow, parity, sign and zero.

The flags live in a register inside the block. They keep their values while no operation is issued. Increment and decrement keep the stored carry. Compare updates the flags but does not write a result. For every subtracting operation the carry flag reports a borrow. Byte operations read only bits 7:0 of the operands, return zeros in the upper result bits, and take carry, overflow and sign from bit 7.

Top module: `int_alu_flags`

## Requirements
- R1: Op code 0 (add) returns dst+src. Op code 1 (add-with-carry) returns dst+src+carry_in. For both, CF is set when a carry leaves the most significant bit of the selected width.
- R2: Op code 2 (subtract) returns dst-src. Op code 3 (subtract-with-borrow) returns dst-src-carry_in. For both, CF is set when the subtraction needs a borrow.
- R3: Op code 4 (increment) returns dst+1 and op code 5 (decrement) returns dst-1. Both update AF, OF, PF, SF and ZF, and CF keeps its previous value.
- R4: Op code 7 (compare) sets all six flags exactly as subtract does. It holds wr_en low and leaves res_q unchanged.
- R5: Op code 6 (negate) returns 0-dst, the two's complement of dst. CF is set unless dst is zero at the selected width.
- R6: op_wide=1 selects 16-bit word operation and op_wide=0 selects 8-bit byte operation. At byte width only operand bits 7:0 are used, res_q bits 15:8 are zero, and CF, OF and SF refer to bit 7.
- R7: AF is set when the operation carries out of bit 3 (adding forms) or borrows into bit 4 (subtracting forms).
- R8: OF is set when the signed result cannot be represented at the selected width. Negating the most negative value is one such case.
- R9: PF is set when res bits 7:0 hold an even number of ones. SF equals the result's top bit at the selected width. ZF is set when the result is zero at the selected width.
- R10: Results, wr_en and flags appear one clock after the cycle with op_valid high. In a cycle with op_valid low, wr_en is 0 on the next cycle and res_q and all flags hold their values.
- R11: While rst_n is low, res_q, wr_en and all six flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Issues an operation this cycle |
| op_code | input | 3 | Operation select, encoding in R1 to R5 |
| op_wide | input | 1 | 1 selects word, 0 selects byte |
| dst | input | W | Destination operand |
| src | input | W | Source operand |
| carry_in | input | 1 | Carry or borrow added by op codes 1 and 3 |
| res_q | output | W | Registered result |
| wr_en | output | 1 | Result is to be written |
| cf | output | 1 | Carry or borrow flag |
| af | output | 1 | Auxiliary carry flag |
| of | output | 1 | Signed overflow flag |
| pf | output | 1 | Parity flag |
| sf | output | 1 | Sign flag |
| zf | output | 1 | Zero flag |

## Verification
The bench uses the default parameters: a 16-bit word width and an 8-bit byte width. Because both widths exist in one build, each test run covers both sets of carry, overflow and sign boundaries: 0x7F/0x80/0xFF at byte width and 0x7FFF/0x8000/0xFFFF at word width. Random byte operations with nonzero upper operand bits check that only bits 7:0 are used. Randomly placed idle cycles check that results and flags hold.

// File: rtl/int_alu_flags.sv
module int_alu_flags #(
  parameter int W  = 16,
  parameter int BW = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  input  logic [2:0]   op_code,
  input  logic         op_wide,
  input  logic [W-1:0] dst,
  input  logic [W-1:0] src,
  input  logic         carry_in,
  output logic [W-1:0] res_q,
  output logic         wr_en,
  output logic         cf,
  output logic         af,
  output logic         of,
  output logic         pf,
  output logic         sf,
  output logic         zf
);
  localparam logic [2:0] OP_ADD = 3'd0, OP_ADC = 3'd1, OP_SUB = 3'd2, OP_SBB = 3'd3,
                         OP_INC = 3'd4, OP_DEC = 3'd5, OP_NEG = 3'd6, OP_CMP = 3'd7;

  logic [W-1:0] msk, opa, opb, rn;
  logic [W:0]   full, cext;
  logic         is_sub, is_step, cin_u, top, am, bm, rm, cf_n, of_n;

  assign msk     = op_wide ? {W{1'b1}} : {{(W-BW){1'b0}}, {BW{1'b1}}};
  assign is_step = (op_code == OP_INC) || (op_code == OP_DEC);
  assign is_sub  = (op_code == OP_SUB) || (op_code == OP_SBB) || (op_code == OP_DEC) ||
                   (op_code == OP_NEG) || (op_code == OP_CMP);
  assign cin_u   = ((op_code == OP_ADC) || (op_code == OP_SBB)) ? carry_in : 1'b0;

  assign opa = (op_code == OP_NEG) ? '0 : (dst & msk);
  assign opb = is_step ? {{(W-1){1'b0}}, 1'b1} :
               (op_code == OP_NEG) ? (dst & msk) : (src & msk);

  assign cext = {{W{1'b0}}, cin_u};
  assign full = is_sub ? ({1'b0, opa} - {1'b0, opb} - cext)
                       : ({1'b0, opa} + {1'b0, opb} + cext);
  assign rn   = full[W-1:0] & msk;

  assign top  = op_wide ? full[W]   : full[BW];
  assign am   = op_wide ? opa[W-1]  : opa[BW-1];
  assign bm   = op_wide ? opb[W-1]  : opb[BW-1];
  assign rm   = op_wide ? rn[W-1]   : rn[BW-1];
  assign of_n = is_sub ? ((am != bm) && (rm != am)) : ((am == bm) && (rm != am));
  assign cf_n = is_step ? cf : top;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      wr_en <= 1'b0;
      {cf, af, of, pf, sf, zf} <= '0;
    end else begin
      wr_en <= op_valid && (op_code != OP_CMP);
      if (op_valid) begin
        if (op_code != OP_CMP) res_q <= rn;
        cf <= cf_n;
        af <= opa[4] ^ opb[4] ^ full[4];
        of <= of_n;
        pf <= ~^rn[7:0];
        sf <= rm;
        zf <= (rn == '0);
      end
    end
  end

  AST_STEP_KEEPS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && is_step |=> cf == $past(cf)); // R3
  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (op_code == OP_CMP) |=> !wr_en && $stable(res_q)); // R4
  AST_NEG_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (op_code == OP_NEG) |=> cf == $past(op_wide ? (dst != '0) : (dst[BW-1:0] != '0))); // R5
  AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !op_wide && (op_code != OP_CMP) |=> res_q[W-1:BW] == '0); // R6
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> zf == (res_q == '0)); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !wr_en && $stable(res_q) && $stable({cf, af, of, pf, sf, zf})); // R10
endmodule

// File: tb/int_alu_flags_test.sv
`timescale 1ns/1ps
module int_alu_flags_test;
  logic        clk = 0, rst_n = 0, op_valid = 0, op_wide = 0, carry_in = 0;
  logic [2:0]  op_code = 0;
  logic [15:0] dst = 0, src = 0, res_q;
  logic        wr_en, cf, af, of, pf, sf, zf;
  int checks = 0, errors = 0;
  bit done = 0;
  int e_res = 0;
  bit e_wr = 0, e_cf = 0, e_af = 0, e_of = 0, e_pf = 0, e_sf = 0, e_zf = 0;

  always #4 clk = ~clk;

  int_alu_flags #(.W(16), .BW(8)) uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code), .op_wide(op_wide),
    .dst(dst), .src(src), .carry_in(carry_in), .res_q(res_q), .wr_en(wr_en),
    .cf(cf), .af(af), .of(of), .pf(pf), .sf(sf), .zf(zf));

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model(input logic [2:0] op, input bit wide, input int d, input int s, input bit ci);
    int n = wide ? 16 : 8;
    int mask = (1 << n) - 1;
    int a, b, c, tot, low, sa, sb, st, r, ones;
    bit sub;
    a = d & mask; b = s & mask; c = 0; sub = 0;
    case (op)
      3'd1: c = int'(ci);
      3'd2: sub = 1;
      3'd3: begin sub = 1; c = int'(ci); end
      3'd4: b = 1;
      3'd5: begin b = 1; sub = 1; end
      3'd6: begin b = a; a = 0; sub = 1; end
      3'd7: sub = 1;
      default: ;
    endcase
    tot = sub ? a - b - c : a + b + c;
    low = sub ? (a & 15) - (b & 15) - c : (a & 15) + (b & 15) + c;
    sa = (a >= (1 << (n-1))) ? a - (1 << n) : a;
    sb = (b >= (1 << (n-1))) ? b - (1 << n) : b;
    st = sub ? sa - sb - c : sa + sb + c;
    r = tot & mask;
    ones = 0;
    for (int i = 0; i < 8; i++) ones += (r >> i) & 1;
    if (op != 3'd4 && op != 3'd5) e_cf = sub ? (tot < 0) : (tot > mask);
    e_af = sub ? (low < 0) : (low > 15);
    e_of = (st > (1 << (n-1)) - 1) || (st < -(1 << (n-1)));
    e_pf = (ones % 2) == 0;
    e_sf = ((r >> (n-1)) & 1) == 1;
    e_zf = (r == 0);
    e_wr = (op != 3'd7);
    if (op != 3'd7) e_res = r;
  endtask

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd0, 3'd1: return "R1";
      3'd2, 3'd3: return "R2";
      3'd4, 3'd5: return "R3";
      3'd6:       return "R5";
      default:    return "R4";
    endcase
  endfunction

  task automatic check_all(input string t);
    chk(t, "res", int'(res_q), e_res);
    chk(t, "wr_en", int'(wr_en), int'(e_wr));
    chk(t, "cf", int'(cf), int'(e_cf));
    chk("R7", "af", int'(af), int'(e_af));
    chk("R8", "of", int'(of), int'(e_of));
    chk("R9", "pf", int'(pf), int'(e_pf));
    chk("R9", "sf", int'(sf), int'(e_sf));
    chk("R9", "zf", int'(zf), int'(e_zf));
  endtask

  task automatic do_op(input logic [2:0] op, input bit wide, input logic [15:0] d,
                       input logic [15:0] s, input bit ci);
    op_valid = 1; op_code = op; op_wide = wide; dst = d; src = s; carry_in = ci;
    model(op, wide, int'(d), int'(s), ci);
    @(negedge clk);
    op_valid = 0;
    check_all(tag_of(op));
    if (!wide && op != 3'd7) chk("R6", "upper byte", int'(res_q[15:8]), 0);
  endtask

  task automatic idle(input logic [15:0] d, input logic [2:0] op);
    op_valid = 0; op_code = op; dst = d; src = ~d; carry_in = 1;
    e_wr = 0;
    @(negedge clk);
    check_all("R10");
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0101));
    repeat (3) @(negedge clk);
    chk("R11", "reset res", int'(res_q), 0);
    chk("R11", "reset wr_en", int'(wr_en), 0);
    chk("R11", "reset flags", int'({cf, af, of, pf, sf, zf}), 0);
    rst_n = 1;
    @(negedge clk);
    do_op(3'd0, 1, 16'hFFFF, 16'h0001, 0);
    do_op(3'd0, 0, 16'h127F, 16'hAB01, 0);
    do_op(3'd1, 0, 16'h00FF, 16'h0000, 1);
    do_op(3'd1, 1, 16'h7FFF, 16'h0000, 1);
    do_op(3'd2, 0, 16'h0080, 16'h0001, 0);
    do_op(3'd3, 1, 16'h0000, 16'h0000, 1);
    do_op(3'd2, 1, 16'h1000, 16'h0001, 0);
    do_op(3'd4, 1, 16'hFFFF, 16'h0000, 0);
    do_op(3'd5, 0, 16'h0000, 16'h0000, 0);
    do_op(3'd0, 1, 16'h0001, 16'h0001, 0);
    do_op(3'd4, 0, 16'h007F, 16'h0000, 0);
    do_op(3'd6, 0, 16'hFF00, 16'h0000, 0);
    do_op(3'd6, 0, 16'h0080, 16'h0000, 0);
    do_op(3'd6, 1, 16'h8000, 16'h0000, 0);
    do_op(3'd6, 1, 16'h0001, 16'h0000, 0);
    do_op(3'd0, 1, 16'h1234, 16'h1111, 0);
    do_op(3'd7, 1, 16'h4321, 16'h4321, 0);
    do_op(3'd7, 0, 16'h0010, 16'h0020, 0);
    idle(16'hAAAA, 3'd0);
    idle(16'h5555, 3'd6);
    for (int k = 0; k < 1500; k++) begin
      logic [2:0] op = 3'($urandom_range(0, 7));
      bit wide = 1'($urandom_range(0, 1));
      logic [15:0] d = 16'($urandom);
      logic [15:0] s = 16'($urandom);
      int pick = $urandom_range(0, 9);
      if (pick == 0) s = wide ? 16'h8000 : 16'h0080;
      if (pick == 1) d = wide ? 16'h7FFF : 16'h007F;
      if (pick == 2) s = d;
      if ($urandom_range(0, 7) == 0) idle(16'($urandom), op);
      do_op(op, wide, d, s, 1'($urandom_range(0, 1)));
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule